// File: doc/BRIEF.md
# Dead-Band Complementary Pair Generator

This block turns one PWM input into a pair of gate-drive outputs, A and B, with a dead band between them. A uses the input, but each of its rising edges is held back by a programmable number of clock cycles. B also uses the input, but each of its falling edges is held back by a second, independent count. This means that whenever the two signals are read as a high-side and low-side complementary pair, neither switch turns on until its partner has been off for the programmed gap.

A two-bit polarity select picks one of four inversion patterns, giving active-high, active-low and the two complementary variants. A bypass control sends the raw input to both outputs without any change. A pulse or gap no longer than the delay that applies to it is removed completely and does not leave a sliver behind. The block suits a half-bridge phase leg that sits after an action-qualifier stage.

Top module: `dbg_deadband`

## Requirements
- R1: While reset is asserted, and after it is released with the input held low, both outputs are low in polarity code 2'b00.
- R2: Outside bypass, the non-inverted A path is high one cycle after a clock edge if and only if the input was sampled high on that edge and on the `red_cycles` edges before it. A therefore falls one cycle after the input is sampled low.
- R3: Outside bypass, the non-inverted B path is high one cycle after a clock edge if and only if the input was sampled high on at least one of that edge and the `fed_cycles` edges before it. B therefore rises one cycle after the input is sampled high.
- R4: A delay value of zero adds no dead time to that edge. The path then follows the input with only the single register cycle.
- R5: A high pulse that lasts `red_cycles` sampled edges or fewer never shows on the A path. This includes the maximum value of 1023.
- R6: A low gap that lasts `fed_cycles` sampled edges or fewer never shows on the B path.
- R7: Polarity select bit 0 inverts A and bit 1 inverts B. Code 2'b00 is active high, 2'b10 is active high complementary, 2'b11 is active low and 2'b01 is active low complementary.
- R8: When `bypass` is high, both outputs equal `pwm_in` in the same cycle, whatever the polarity and delay settings.
- R9: Outside bypass, A and B are never both high in code 2'b10 and never both low in code 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all delays are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_in | input | 1 | PWM source waveform |
| red_cycles | input | 10 | Rising-edge delay applied to A, in cycles |
| fed_cycles | input | 10 | Falling-edge delay applied to B, in cycles |
| pol_sel | input | 2 | Polarity code; bit 0 inverts A, bit 1 inverts B |
| bypass | input | 1 | Pass the input straight to both outputs |
| out_a | output | 1 | Gate output A |
| out_b | output | 1 | Gate output B |

## Verification
The run-length counter for each edge is hidden inside the block, so the ports are the only place a counting error can be seen. A counter that is off by one moves an A rising edge or a B falling edge by exactly one cycle, and the bench catches this on the first edge it compares. A counter that saturates or clears wrongly either lets a short pulse through that should have been swallowed or drops a long one. The bench catches both cases within one pulse width. A lost ordering between the two paths shows up at once in the complementary codes, where the outputs overlap or both go inactive together.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  // bit 0 inverts lane A, bit 1 inverts lane B
  typedef enum logic [1:0] {
    POL_ACT_HIGH      = 2'b00,
    POL_ACT_LOW_COMP  = 2'b01,
    POL_ACT_HIGH_COMP = 2'b10,
    POL_ACT_LOW       = 2'b11
  } pol_mode_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/dbg_edge_delay.sv
// Delays one kind of edge by a run-length test on the input level.
// RISE_EDGE=1: output high only after the input was high for dly+1 edges.
// RISE_EDGE=0: output low only after the input was low for dly+1 edges.
module dbg_edge_delay #(
  parameter int unsigned DLY_W     = 10,
  parameter bit          RISE_EDGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [DLY_W-1:0] dly,
  output logic             sig_out
);
  localparam int unsigned        CW  = DLY_W + 1;
  localparam logic [CW-1:0]      SAT = {1'b1, {DLY_W{1'b0}}};
  localparam logic [CW-1:0]      RUN_RST = RISE_EDGE ? '0 : SAT;

  logic [CW-1:0] run_q, run_nxt;
  logic          run_en;
  logic          lvl, qual, out_nxt, out_en;

  always_comb begin
    lvl = RISE_EDGE ? sig_in : !sig_in;
    if (!lvl)             run_nxt = '0;
    else if (run_q == SAT) run_nxt = SAT;
    else                  run_nxt = run_q + 1'b1;
    qual    = lvl && (run_nxt > {1'b0, dly});
    out_nxt = RISE_EDGE ? qual : !qual;
    run_en  = (run_nxt != run_q);
    out_en  = (out_nxt != sig_out);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= RUN_RST;
      sig_out <= 1'b0;
    end else begin
      if (run_en) run_q   <= run_nxt;
      if (out_en) sig_out <= out_nxt;
    end
  end
endmodule

// File: rtl/dbg_polarity.sv
module dbg_polarity
  import dbg_pkg::*;
(
  input  logic      pwm_in,
  input  logic      dly_a,
  input  logic      dly_b,
  input  pol_mode_e pol,
  input  logic      bypass,
  output logic      out_a,
  output logic      out_b
);
  logic [LANES-1:0] lane_in, lane_out;

  assign lane_in = {dly_b, dly_a};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_out[g] = bypass ? pwm_in : (lane_in[g] ^ pol[g]);
  end

  assign out_a = lane_out[0];
  assign out_b = lane_out[1];
endmodule

// File: rtl/dbg_deadband.sv
module dbg_deadband
  import dbg_pkg::*;
#(
  parameter int unsigned DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [DLY_W-1:0] red_cycles,
  input  logic [DLY_W-1:0] fed_cycles,
  input  logic [1:0]       pol_sel,
  input  logic             bypass,
  output logic             out_a,
  output logic             out_b
);
  logic rst_q_n;
  logic dly_a, dly_b;

  dbg_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  dbg_edge_delay #(.DLY_W(DLY_W), .RISE_EDGE(1'b1)) u_rise (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .sig_in (pwm_in),
    .dly    (red_cycles),
    .sig_out(dly_a)
  );

  dbg_edge_delay #(.DLY_W(DLY_W), .RISE_EDGE(1'b0)) u_fall (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .sig_in (pwm_in),
    .dly    (fed_cycles),
    .sig_out(dly_b)
  );

  dbg_polarity u_pol (
    .pwm_in(pwm_in),
    .dly_a (dly_a),
    .dly_b (dly_b),
    .pol   (pol_mode_e'(pol_sel)),
    .bypass(bypass),
    .out_a (out_a),
    .out_b (out_b)
  );
endmodule

// File: rtl/dbg_deadband_chk.sv
module dbg_deadband_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_in,
  input logic [1:0] pol_sel,
  input logic       bypass,
  input logic       out_a,
  input logic       out_b,
  input logic       dly_a,
  input logic       dly_b
);
  // R9: complementary high-active pair never overlaps
  a_r9_ahc_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && pol_sel == 2'b10) |-> !(out_a && out_b));

  // R9: complementary low-active pair never both active
  a_r9_alc_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && pol_sel == 2'b01) |-> (out_a || out_b));

  // R9: the rise-delayed lane implies the fall-delayed lane
  a_r9_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    dly_a |-> dly_b);

  // R8: bypass hands the input straight through
  a_r8_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (out_a == pwm_in && out_b == pwm_in));

  // R2: A drops one cycle after a low sample
  a_r2_fall_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && pol_sel == 2'b00 && $past(rst_n) && !$past(pwm_in)) |-> !out_a);

  // R3: B rises one cycle after a high sample
  a_r3_rise_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && pol_sel == 2'b00 && $past(rst_n) && $past(pwm_in)) |-> out_b);
endmodule

bind dbg_deadband dbg_deadband_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .pwm_in (pwm_in),
  .pol_sel(pol_sel),
  .bypass (bypass),
  .out_a  (out_a),
  .out_b  (out_b),
  .dly_a  (dly_a),
  .dly_b  (dly_b)
);

// File: tb/dbg_deadband_test.sv
`timescale 1ns/1ps
module dbg_deadband_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in;
  logic [9:0] red_cycles, fed_cycles;
  logic [1:0] pol_sel;
  logic       bypass;
  logic       out_a, out_b;

  int n_chk = 0;
  int n_bad = 0;
  int n_step = 0;
  bit hist [0:8191];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dbg_deadband uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .red_cycles(red_cycles), .fed_cycles(fed_cycles),
    .pol_sel(pol_sel), .bypass(bypass),
    .out_a(out_a), .out_b(out_b)
  );

  function automatic bit past_in(int idx);
    return (idx < 0) ? 1'b0 : hist[idx];
  endfunction

  // A: all recent samples high; B: any recent sample high
  function automatic bit exp_a();
    bit r = 1'b1;
    for (int k = 0; k <= int'(red_cycles); k++) r &= past_in(n_step - 1 - k);
    return r;
  endfunction

  function automatic bit exp_b();
    bit r = 1'b0;
    for (int k = 0; k <= int'(fed_cycles); k++) r |= past_in(n_step - 1 - k);
    return r;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at step %0d: got %b expected %b", req, what, n_step, act, exp);
    end
  endtask

  // apply one input sample and check both outputs after the edge
  task automatic tick(string req, bit v);
    pwm_in = v;
    hist[n_step] = v;
    n_step++;
    @(posedge clk); #2;
    check(req, "out_a", out_a, exp_a() ^ pol_sel[0]);
    check(req, "out_b", out_b, exp_b() ^ pol_sel[1]);
  endtask

  task automatic pulses(string req, int hi, int lo, int reps);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < hi; i++) tick(req, 1'b1);
      for (int i = 0; i < lo; i++) tick(req, 1'b0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwm_in = 1'b0; bypass = 1'b0; pol_sel = 2'b00;
    red_cycles = 10'd0; fed_cycles = 10'd0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "out_a in reset", out_a, 1'b0);
    check("R1", "out_b in reset", out_b, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick("R1", 1'b0);
  endtask

  task automatic t_zero_delay();
    red_cycles = 10'd0; fed_cycles = 10'd0; pol_sel = 2'b00;
    pulses("R4", 1, 1, 4);
    pulses("R4", 3, 2, 3);
  endtask

  task automatic t_edges();
    red_cycles = 10'd5; fed_cycles = 10'd3; pol_sel = 2'b00;
    pulses("R2", 12, 9, 3);
    red_cycles = 10'd2; fed_cycles = 10'd7;
    pulses("R3", 10, 12, 3);
  endtask

  task automatic t_swallow();
    pol_sel = 2'b00;
    red_cycles = 10'd6; fed_cycles = 10'd0;
    pulses("R5", 4, 8, 2);
    pulses("R5", 6, 8, 2);   // equal to delay: swallowed
    pulses("R5", 7, 8, 2);   // one longer: single-cycle A pulse
    red_cycles = 10'd0; fed_cycles = 10'd5;
    pulses("R6", 10, 3, 2);
    pulses("R6", 10, 5, 2);  // equal to delay: gap swallowed
    pulses("R6", 10, 6, 2);
    red_cycles = 10'd1023; fed_cycles = 10'd0;
    pulses("R5", 40, 4, 2);  // maximum delay hides a long pulse
    for (int i = 0; i < 4; i++) tick("R5", 1'b0);
  endtask

  task automatic t_polarity();
    red_cycles = 10'd2; fed_cycles = 10'd3;
    for (int m = 0; m < 4; m++) begin
      pol_sel = 2'(m);
      pulses("R7", 7, 6, 2);
    end
  endtask

  task automatic t_bypass();
    bit v;
    red_cycles = 10'd4; fed_cycles = 10'd4;
    bypass = 1'b1;
    for (int m = 0; m < 4; m++) begin
      pol_sel = 2'(m);
      for (int i = 0; i < 6; i++) begin
        v = (i % 3) != 0;
        pwm_in = v;
        hist[n_step] = v;
        n_step++;
        #1;
        check("R8", "out_a bypass", out_a, v);
        check("R8", "out_b bypass", out_b, v);
        @(posedge clk); #2;
      end
    end
    bypass = 1'b0;
    pol_sel = 2'b00;
    for (int i = 0; i < 6; i++) tick("R8", 1'b0);
  endtask

  task automatic t_overlap();
    red_cycles = 10'd3; fed_cycles = 10'd2;
    pol_sel = 2'b10;
    for (int i = 0; i < 30; i++) begin
      tick("R9", (i % 7) < 4);
      check("R9", "AHC overlap", out_a & out_b, 1'b0);
    end
    pol_sel = 2'b01;
    for (int i = 0; i < 30; i++) begin
      tick("R9", (i % 5) < 2);
      check("R9", "ALC both low", out_a | out_b, 1'b1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_zero_delay();
    t_edges();
    t_swallow();
    t_polarity();
    t_bypass();
    t_overlap();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule